// File: doc/BRIEF.md
# Branch Target Predictor with Misprediction Update

This block is a direct-mapped branch target buffer. An issuing branch presents its own address on the lookup port and gets back the address that fetch should go to next. On a hit that is a full stored target. On a miss it is the next sequential address. The issue logic tags the branch with this predicted address.

When the branch resolves, the execution side compares the prediction with the real next address. It then reports the branch address, the real next address and a mispredict flag on the resolve port. A mispredict rewrites the entry. A parameter sets how eager the rewrite is. With one bit of confidence, a hit entry is replaced on every mispredict. With two bits, a hit entry is replaced only after two mispredicts in a row, which keeps loop-closing branches stable across a single loop exit. Two saturating counters tally correct and wrong resolutions for performance statistics.

Top module: `btb_predictor`

## Requirements
- R1: A lookup whose index slot holds a valid entry with a matching tag returns the stored target on lk_pred_o with lk_hit_o=1, in the same cycle as the address.
- R2: A lookup that does not hit returns lk_addr_i+1 (modulo 2^ADDR_W) with lk_hit_o=0. For example, address 16'hFFFF gives 16'h0000.
- R3: After reset every entry is invalid, so all lookups miss, and both statistics counters read zero.
- R4: A resolve with res_mispred_i=0 never changes any stored tag or target. On a hit entry it clears that entry's mispredict streak.
- R5: With CNT_W=1, a mispredict replaces the entry's tag and target with the resolved branch address and target. Lookups see the new entry from the next cycle onward.
- R6: With CNT_W=2, a mispredict on a hit entry with no streak keeps the old target and records a streak. A second consecutive mispredict replaces the entry. A correct resolve in between clears the streak.
- R7: In either mode, a mispredict whose slot is invalid or holds another tag installs the entry at once.
- R8: The slot index is the low IDX_W address bits and the tag is the remaining bits. Two branches that share an index evict each other.
- R9: correct_cnt_o increments by one on each resolve with res_mispred_i=0 and saturates at 2^STAT_W-1.
- R10: wrong_cnt_o increments by one on each resolve with res_mispred_i=1 and saturates at 2^STAT_W-1.
- R11: With res_valid_i=0 the table and both counters are unchanged, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_addr_i | input | ADDR_W | Address of the issuing branch |
| lk_pred_o | output | ADDR_W | Predicted next address |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| res_valid_i | input | 1 | Resolve request this cycle |
| res_addr_i | input | ADDR_W | Address of the resolved branch |
| res_target_i | input | ADDR_W | Actual next address of the resolved branch |
| res_mispred_i | input | 1 | Prediction did not match the actual next address |
| correct_cnt_o | output | STAT_W | Saturating count of correct resolutions |
| wrong_cnt_o | output | STAT_W | Saturating count of mispredicted resolutions |

## Verification
The lookup result is combinational. The bench sets the address and reads the prediction 1 ns later, in the same cycle. A resolve is written on the clock edge that samples it. The bench therefore holds a resolve for exactly one rising edge and checks lookups and counters only after that edge, at the following falling edge. A resolve never bypasses to a lookup in the same cycle, so no check samples both in one cycle. Both confidence widths run side by side against a bench model built from the requirements, over every index and an address stream generated by an LFSR.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_INSTALL,
    UPD_STRIKE,
    UPD_CLEAR
  } btb_upd_e;
endpackage

// File: rtl/btb_sat_counter.sv
module btb_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + W'(1);
  end

  AST_STAT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o >= $past(cnt_o)); // R9 R10
  AST_STAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o != MAX) |=> cnt_o == $past(cnt_o) + W'(1)); // R9 R10
  AST_STAT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX) |=> cnt_o == MAX); // R10
endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic [ADDR_W-1:0] lk_pred_o,
  output logic              lk_hit_o,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_addr_i,
  input  logic [ADDR_W-1:0] res_target_i,
  input  logic              res_mispred_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - IDX_W;
  localparam logic [CNT_W-1:0] STRIKE_LIM = CNT_W'(CNT_W - 1);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q;
  logic [ENTRIES-1:0][CNT_W-1:0]  strike_q;

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             rs_hit;
  btb_upd_e         upd;

  assign lk_idx = lk_addr_i[IDX_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W];
  assign rs_idx = res_addr_i[IDX_W-1:0];
  assign rs_tag = res_addr_i[ADDR_W-1:IDX_W];

  assign lk_hit_o  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_pred_o = lk_hit_o ? tgt_q[lk_idx] : lk_addr_i + ADDR_W'(1);

  assign rs_hit = valid_q[rs_idx] && (tag_q[rs_idx] == rs_tag);

  always_comb begin
    upd = UPD_NONE;
    if (res_valid_i) begin
      if (res_mispred_i) begin
        // replace when absent or the streak has reached its limit
        if (!rs_hit || strike_q[rs_idx] == STRIKE_LIM) upd = UPD_INSTALL;
        else                                           upd = UPD_STRIKE;
      end else if (rs_hit) begin
        upd = UPD_CLEAR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      tag_q    <= '0;
      tgt_q    <= '0;
      strike_q <= '0;
    end else begin
      unique case (upd)
        UPD_INSTALL: begin
          valid_q[rs_idx]  <= 1'b1;
          tag_q[rs_idx]    <= rs_tag;
          tgt_q[rs_idx]    <= res_target_i;
          strike_q[rs_idx] <= '0;
        end
        UPD_STRIKE: strike_q[rs_idx] <= strike_q[rs_idx] + CNT_W'(1);
        UPD_CLEAR:  strike_q[rs_idx] <= '0;
        default: ;
      endcase
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(tgt_q) && $stable(tag_q) && $stable(valid_q)); // R11
  AST_CORRECT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_mispred_i) |=> $stable(tgt_q) && $stable(tag_q)); // R4
  AST_MISS_INSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_mispred_i && !rs_hit)
      |=> tgt_q[$past(rs_idx)] == $past(res_target_i)); // R7

  generate
    if (CNT_W == 1) begin : g_onebit
      AST_ONEBIT_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_i && res_mispred_i)
          |=> tgt_q[$past(rs_idx)] == $past(res_target_i)); // R5
    end else begin : g_multibit
      AST_TWOBIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_i && res_mispred_i && rs_hit && strike_q[rs_idx] == '0)
          |=> $stable(tgt_q)); // R6
    end
  endgenerate
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic [ADDR_W-1:0] lk_pred_o,
  output logic              lk_hit_o,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_addr_i,
  input  logic [ADDR_W-1:0] res_target_i,
  input  logic              res_mispred_i,
  output logic [STAT_W-1:0] correct_cnt_o,
  output logic [STAT_W-1:0] wrong_cnt_o
);
  logic inc_ok, inc_bad;

  assign inc_ok  = res_valid_i && !res_mispred_i;
  assign inc_bad = res_valid_i &&  res_mispred_i;

  btb_table #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_addr_i    (lk_addr_i),
    .lk_pred_o    (lk_pred_o),
    .lk_hit_o     (lk_hit_o),
    .res_valid_i  (res_valid_i),
    .res_addr_i   (res_addr_i),
    .res_target_i (res_target_i),
    .res_mispred_i(res_mispred_i)
  );

  btb_sat_counter #(.W(STAT_W)) u_cnt_ok (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc_ok),
    .cnt_o (correct_cnt_o)
  );

  btb_sat_counter #(.W(STAT_W)) u_cnt_bad (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc_bad),
    .cnt_o (wrong_cnt_o)
  );

  AST_STATS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> ((correct_cnt_o != $past(correct_cnt_o)) +
                     (wrong_cnt_o   != $past(wrong_cnt_o))) <= 1); // R9 R10
  AST_IDLE_STATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(correct_cnt_o) && $stable(wrong_cnt_o)); // R11
endmodule

// File: tb/btb_predictor_bench.sv
`timescale 1ns/1ps
module btb_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lk_addr = '0;
  logic        res_valid = 1'b0;
  logic [15:0] res_addr = '0, res_target = '0;
  logic        res_mis = 1'b0;

  logic [15:0] pred [2];
  logic        hit [2];
  logic [7:0]  cnt_ok [2];
  logic [7:0]  cnt_bad [2];

  int checks = 0, fails = 0;
  bit done = 0;

  // model, index 0 = one-bit mode, index 1 = two-bit mode
  logic        m_v   [2][16];
  logic [11:0] m_tag [2][16];
  logic [15:0] m_tgt [2][16];
  int          m_str [2][16];
  int          m_ok = 0, m_bad = 0;

  always #2.5 clk = ~clk;

  btb_predictor #(.CNT_W(1)) u_btb_predictor_1b (
    .clk_i(clk), .rst_ni(rst_n), .lk_addr_i(lk_addr), .lk_pred_o(pred[0]),
    .lk_hit_o(hit[0]), .res_valid_i(res_valid), .res_addr_i(res_addr),
    .res_target_i(res_target), .res_mispred_i(res_mis),
    .correct_cnt_o(cnt_ok[0]), .wrong_cnt_o(cnt_bad[0]));

  btb_predictor #(.CNT_W(2)) u_btb_predictor (
    .clk_i(clk), .rst_ni(rst_n), .lk_addr_i(lk_addr), .lk_pred_o(pred[1]),
    .lk_hit_o(hit[1]), .res_valid_i(res_valid), .res_addr_i(res_addr),
    .res_target_i(res_target), .res_mispred_i(res_mis),
    .correct_cnt_o(cnt_ok[1]), .wrong_cnt_o(cnt_bad[1]));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic model_res(input logic [15:0] a, input logic [15:0] t, input logic mis);
    for (int m = 0; m < 2; m++) begin
      int i = int'(a[3:0]);
      logic rh = m_v[m][i] && m_tag[m][i] == a[15:4];
      if (mis) begin
        if (!rh || m_str[m][i] == m) begin
          m_v[m][i] = 1'b1; m_tag[m][i] = a[15:4]; m_tgt[m][i] = t; m_str[m][i] = 0;
        end else m_str[m][i]++;
      end else if (rh) m_str[m][i] = 0;
    end
    if (mis) begin if (m_bad < 255) m_bad++; end
    else     begin if (m_ok  < 255) m_ok++;  end
  endtask

  // one resolve, held for exactly one rising edge; returns at the next falling edge
  task automatic do_res(input logic [15:0] a, input logic [15:0] t, input logic mis);
    @(negedge clk);
    res_valid = 1'b1; res_addr = a; res_target = t; res_mis = mis;
    @(negedge clk);
    res_valid = 1'b0;
    model_res(a, t, mis);
  endtask

  task automatic chk_lk(input string req, input logic [15:0] a);
    lk_addr = a;
    #1;
    for (int m = 0; m < 2; m++) begin
      int i = int'(a[3:0]);
      logic eh = m_v[m][i] && m_tag[m][i] == a[15:4];
      chk(req, {31'd0, hit[m]}, {31'd0, eh});
      chk(req, {16'd0, pred[m]}, {16'd0, eh ? m_tgt[m][i] : a + 16'd1});
    end
  endtask

  task automatic chk_cnt(input string req);
    for (int m = 0; m < 2; m++) begin
      chk(req, {24'd0, cnt_ok[m]}, m_ok);
      chk(req, {24'd0, cnt_bad[m]}, m_bad);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++) begin
        m_v[m][i] = 0; m_tag[m][i] = '0; m_tgt[m][i] = '0; m_str[m][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: empty after reset, R2 sequential fallback
    chk_cnt("R3");
    for (int i = 0; i < 16; i++) chk_lk("R3", 16'h0230 + 16'(i));
    chk_lk("R2", 16'hFFFF);

    // R7: install every slot from a miss
    for (int i = 0; i < 16; i++) do_res(16'h0100 + 16'(i), 16'h4000 + 16'(i * 7), 1'b1);
    for (int i = 0; i < 16; i++) chk_lk("R1", 16'h0100 + 16'(i));
    chk_lk("R8", 16'h0205);
    chk_cnt("R10");

    // R5/R6: single mispredict on hit entry
    do_res(16'h0103, 16'h7777, 1'b1);
    chk_lk("R5", 16'h0103);
    chk(  "R6", {16'd0, pred[1]}, 32'h4015);
    do_res(16'h0103, 16'h7777, 1'b1);
    chk_lk("R6", 16'h0103);
    chk(  "R6", {16'd0, pred[1]}, 32'h7777);

    // R6/R4: correct resolve breaks the streak
    do_res(16'h0106, 16'h5555, 1'b1);
    do_res(16'h0106, 16'h1234, 1'b0);
    chk_lk("R4", 16'h0106);
    do_res(16'h0106, 16'h5555, 1'b1);
    chk_lk("R6", 16'h0106);
    chk(  "R6", {16'd0, pred[1]}, 32'h402A);

    // R11: idle resolve inputs ignored
    @(negedge clk);
    res_valid = 1'b0; res_addr = 16'h0109; res_target = 16'hDEAD; res_mis = 1'b1;
    @(negedge clk);
    chk_lk("R11", 16'h0109);
    chk_cnt("R11");

    // R8: aliasing eviction
    do_res(16'h0A0C, 16'h0BBB, 1'b1);
    chk_lk("R8", 16'h010C);
    chk_lk("R8", 16'h0A0C);

    // sweep with LFSR addresses
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {10'd0, lfsr[9:4]} << 4 | 16'(lfsr[3:0]);
      do_res(a, lfsr ^ 16'h5A5A, lfsr[11]);
      chk_lk("R1", a);
      chk_lk("R2", a ^ 16'h0010);
    end
    chk_cnt("R9");

    // saturation of both counters
    for (int n = 0; n < 260; n++) do_res(16'h0001, 16'h0002, 1'b0);
    chk_cnt("R9");
    for (int n = 0; n < 260; n++) do_res(16'h0001, 16'h0002, 1'b1);
    chk_cnt("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule